// File: doc/BRIEF.md
# Direct-Mapped Write-Through Cache

This block is a small direct-mapped cache placed between a processor load/store port and a word-wide main memory port. It splits each byte address into three fields. Low bits select a byte and are ignored. Middle bits pick the single line that may hold the word. High bits are compared with the tag stored in that line. Each line holds a valid flag, a tag and one data word. A read that hits returns its data combinationally in the same cycle. A read that misses holds the processor in a stall until the word has been fetched from memory and placed in its line.

Every store goes to memory through a small posted write queue, so the processor continues at once. A store that hits also updates the line. A store that misses leaves the cache untouched. A read miss lets the queue empty before it issues its own memory read, so it always sees the newest value. Line count, address width, word width and queue depth are parameters.

Top module: `dm_wt_cache`

## Requirements
- R1: With default geometry the byte address bits [1:0] are ignored, bits [4:2] select one of 8 lines (word address modulo 8), and bits [6:5] form the tag; memory is addressed by the word address cpu_addr[6:2].
- R2: Reset clears every valid flag, so the first read of any word after reset is a miss.
- R3: A read hits only when the selected line is valid and its tag equals the address tag; a hit returns the line's word with cpu_stall low in the same cycle.
- R4: A read miss raises cpu_stall, reads the word at its word address from memory, writes valid, tag and data into the selected line, and then completes with the fetched word.
- R5: A write whose address hits updates the line's word, so a following read hits and returns the new value, and the write also reaches memory.
- R6: A write that misses changes memory only; the line keeps its previous contents and a later read of the written word is a miss that returns the new value.
- R7: Writes are queued in a 4-entry buffer and accepted without stall while it has room; a write arriving when it holds 4 entries is stalled; queued writes reach memory in acceptance order.
- R8: A read miss issues its memory read only when the write buffer is empty.
- R9: Reading word addresses 0, 8, 0, 6, 8, 16 from reset produces six misses.
- R10: Once mem_req is raised, mem_req, mem_we and mem_addr stay constant until the cycle in which mem_ack is high; mem_ack ends that transfer and read data is taken from mem_rdata in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until accepted |
| cpu_we | input | 1 | 1 for a store, 0 for a load |
| cpu_addr | input | ADDR_W (7) | Byte address |
| cpu_wdata | input | DATA_W (32) | Store data |
| cpu_rdata | output | DATA_W (32) | Load data, valid when the read is not stalled |
| cpu_stall | output | 1 | Access not accepted in this cycle |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 for a memory write, 0 for a read |
| mem_addr | output | ADDR_W-2 (5) | Memory word address |
| mem_wdata | output | DATA_W (32) | Memory write data |
| mem_rdata | input | DATA_W (32) | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Transfer complete, high for one cycle |

## Verification
The hardest case to reach is a read miss that comes while stores are still queued. The read must wait for the queue to empty and then return the newly written value rather than old memory contents. The bench slows the memory model to several cycles per transfer and issues a store miss followed immediately by a load of the same word. At every memory read, the memory model compares the writes it has completed with the writes the bench has issued. The same slow memory, fed stores on back-to-back cycles, fills the queue so that the fifth store must stall.

// File: rtl/cwt_pkg.sv
package cwt_pkg;
  typedef enum logic {
    CTL_RUN   = 1'b0,
    CTL_FETCH = 1'b1
  } ctl_state_e;
endpackage

// File: rtl/cwt_lines.sv
module cwt_lines #(
  parameter int LINES  = 8,
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 2,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  look_idx,
  output logic              look_valid,
  output logic [TAG_W-1:0]  look_tag,
  output logic [DATA_W-1:0] look_data,
  input  logic              fill_en,
  input  logic              upd_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] wr_data
);
  logic [LINES-1:0]  vbits;
  logic [TAG_W-1:0]  tags  [LINES];
  logic [DATA_W-1:0] words [LINES];

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic              sel;
    logic              v_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] word_q;

    assign sel = (wr_idx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (rst)                v_q <= 1'b0;
      else if (fill_en && sel) v_q <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fill_en && sel)              tag_q  <= fill_tag;
      if ((fill_en || upd_en) && sel)  word_q <= wr_data;
    end

    assign vbits[i] = v_q;
    assign tags[i]  = tag_q;
    assign words[i] = word_q;
  end

  assign look_valid = vbits[look_idx];
  assign look_tag   = tags[look_idx];
  assign look_data  = words[look_idx];
endmodule

// File: rtl/cwt_wbuf.sv
module cwt_wbuf #(
  parameter int DEPTH = 4,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          empty,
  output logic          full
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;

  logic [AW-1:0]    q_addr [DEPTH];
  logic [DW-1:0]    q_data [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] used;

  function automatic logic [PTR_W-1:0] step(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) begin
      q_addr[wr_ptr] <= push_addr;
      q_data[wr_ptr] <= push_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      used   <= '0;
    end else begin
      if (push) wr_ptr <= step(wr_ptr);
      if (pop)  rd_ptr <= step(rd_ptr);
      used <= used + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_addr = q_addr[rd_ptr];
  assign head_data = q_data[rd_ptr];
  assign empty     = (used == '0);
  assign full      = (used == CNT_W'(DEPTH));
endmodule

// File: rtl/dm_wt_cache.sv
module dm_wt_cache
  import cwt_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int LINES    = 8,
  parameter int WB_DEPTH = 4
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                cpu_req,
  input  logic                                cpu_we,
  input  logic [ADDR_W-1:0]                   cpu_addr,
  input  logic [DATA_W-1:0]                   cpu_wdata,
  output logic [DATA_W-1:0]                   cpu_rdata,
  output logic                                cpu_stall,
  output logic                                mem_req,
  output logic                                mem_we,
  output logic [ADDR_W-$clog2(DATA_W/8)-1:0]  mem_addr,
  output logic [DATA_W-1:0]                   mem_wdata,
  input  logic [DATA_W-1:0]                   mem_rdata,
  input  logic                                mem_ack
);
  localparam int OFF_W   = $clog2(DATA_W / 8);
  localparam int IDX_W   = $clog2(LINES);
  localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;
  localparam int WADDR_W = ADDR_W - OFF_W;

  // address field helpers
  function automatic logic [IDX_W-1:0] line_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction
  function automatic logic [WADDR_W-1:0] word_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:OFF_W];
  endfunction

  ctl_state_e          state;
  logic [IDX_W-1:0]    req_idx;
  logic [TAG_W-1:0]    req_tag;
  logic [WADDR_W-1:0]  req_word;
  logic                look_valid;
  logic [TAG_W-1:0]    look_tag;
  logic [DATA_W-1:0]   look_data;
  logic                lookup_hit;
  logic                rd_miss;
  logic                fetch_active;
  logic                fill_en;
  logic                upd_en;
  logic                wb_push, wb_pop, wb_empty, wb_full;
  logic [WADDR_W-1:0]  wb_head_addr;
  logic [DATA_W-1:0]   wb_head_data;

  assign req_idx  = line_of(cpu_addr);
  assign req_tag  = tag_of(cpu_addr);
  assign req_word = word_of(cpu_addr);

  cwt_lines #(
    .LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) u_lines (
    .clk(clk), .rst(rst),
    .look_idx(req_idx), .look_valid(look_valid), .look_tag(look_tag),
    .look_data(look_data),
    .fill_en(fill_en), .upd_en(upd_en), .wr_idx(req_idx),
    .fill_tag(req_tag),
    .wr_data(fill_en ? mem_rdata : cpu_wdata)
  );

  cwt_wbuf #(
    .DEPTH(WB_DEPTH), .AW(WADDR_W), .DW(DATA_W)
  ) u_wbuf (
    .clk(clk), .rst(rst),
    .push(wb_push), .push_addr(req_word), .push_data(cpu_wdata),
    .pop(wb_pop), .head_addr(wb_head_addr), .head_data(wb_head_data),
    .empty(wb_empty), .full(wb_full)
  );

  assign lookup_hit   = look_valid && (look_tag == req_tag);
  assign rd_miss      = cpu_req && !cpu_we && !lookup_hit;
  assign fetch_active = (state == CTL_FETCH);

  // store path: queue always, update line only on a hit
  assign wb_push = cpu_req && cpu_we && !wb_full;
  assign upd_en  = wb_push && lookup_hit;
  assign wb_pop  = mem_ack && !fetch_active;
  assign fill_en = fetch_active && mem_ack;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= CTL_RUN;
    end else begin
      unique case (state)
        CTL_RUN:   if (rd_miss && wb_empty) state <= CTL_FETCH;
        CTL_FETCH: if (mem_ack)             state <= CTL_RUN;
        default:   state <= CTL_RUN;
      endcase
    end
  end

  always_comb begin
    cpu_stall = 1'b0;
    if (cpu_req) cpu_stall = cpu_we ? wb_full : !lookup_hit;
  end
  assign cpu_rdata = look_data;

  assign mem_req   = fetch_active || !wb_empty;
  assign mem_we    = !fetch_active;
  assign mem_addr  = fetch_active ? req_word : wb_head_addr;
  assign mem_wdata = wb_head_data;
endmodule

// File: rtl/cwt_checker.sv
module cwt_checker #(
  parameter int ADDR_W  = 7,
  parameter int WADDR_W = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               cpu_req,
  input logic               cpu_we,
  input logic [ADDR_W-1:0]  cpu_addr,
  input logic               cpu_stall,
  input logic               lookup_hit,
  input logic               wb_push,
  input logic               wb_full,
  input logic               wb_empty,
  input logic               fill_en,
  input logic               mem_req,
  input logic               mem_we,
  input logic               mem_ack,
  input logic [WADDR_W-1:0] mem_addr
);
  AST_HIT_NO_STALL: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we && lookup_hit |-> !cpu_stall); // R3
  AST_MISS_STALLS: assert property (@(posedge clk) disable iff (rst)
    cpu_req && !cpu_we && !lookup_hit |-> cpu_stall); // R4
  AST_FILL_THEN_HIT: assert property (@(posedge clk) disable iff (rst)
    fill_en && cpu_req && cpu_stall |=> lookup_hit); // R4
  AST_HELD_WHILE_STALLED: assert property (@(posedge clk) disable iff (rst)
    cpu_req && cpu_stall |=> cpu_req && $stable(cpu_addr) && $stable(cpu_we)); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    wb_full |-> !wb_push); // R7
  AST_READ_AFTER_DRAIN: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_we |-> wb_empty); // R8
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R10
endmodule

bind dm_wt_cache cwt_checker #(.ADDR_W(ADDR_W), .WADDR_W(WADDR_W)) u_cwt_checker (
  .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
  .cpu_stall(cpu_stall), .lookup_hit(lookup_hit), .wb_push(wb_push),
  .wb_full(wb_full), .wb_empty(wb_empty), .fill_en(fill_en),
  .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/dm_wt_cache_test.sv
`timescale 1ns/1ps
module dm_wt_cache_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [6:0]  cpu_addr = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic        cpu_stall;
  logic        mem_req, mem_we;
  logic [4:0]  mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        mem_ack = 1'b0;

  int checks = 0, errors = 0;
  bit done = 0;

  logic [31:0] mem    [32];
  logic [31:0] expmem [32];
  bit          sh_v   [8];
  int          sh_t   [8];
  logic [4:0]  exp_wa [1024];
  logic [31:0] exp_wd [1024];
  int pushes = 0, wr_done = 0, mem_lat = 2, lat_cnt = 0;
  bit          last_miss;
  bit          hold_req = 0;
  logic [4:0]  hold_addr;
  logic        hold_we;

  dm_wt_cache uut (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_stall(cpu_stall),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  always #4 clk = ~clk;

  function automatic logic [31:0] memval(input int w);
    return 32'hC0DE_0000 + 32'(w) * 32'h0101;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  // memory model: fixed latency, one-cycle ack
  always @(posedge clk) begin
    if (rst) begin
      mem_ack <= 1'b0; lat_cnt <= 0; hold_req <= 1'b0;
    end else begin
      if (hold_req)
        chk(mem_req && mem_addr == hold_addr && mem_we == hold_we, "R10",
            "request held", {27'd0, mem_addr}, {27'd0, hold_addr});
      hold_req  <= mem_req && !mem_ack;
      hold_addr <= mem_addr;
      hold_we   <= mem_we;
      mem_ack   <= 1'b0;
      if (mem_req && !mem_ack) begin
        if (lat_cnt >= mem_lat) begin
          lat_cnt <= 0;
          mem_ack <= 1'b1;
          if (mem_we) begin
            chk(mem_addr == exp_wa[wr_done] && mem_wdata == exp_wd[wr_done], "R7",
                "write order", mem_wdata, exp_wd[wr_done]);
            mem[mem_addr] = mem_wdata;
            wr_done = wr_done + 1;
          end else begin
            chk(wr_done == pushes, "R8", "read before drain", 32'(wr_done), 32'(pushes));
            mem_rdata <= mem[mem_addr];
          end
        end else begin
          lat_cnt <= lat_cnt + 1;
        end
      end
    end
  end

  task automatic access(input bit we, input logic [6:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int st);
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
    st = 0;
    #1;
    while (cpu_stall && st < 2000) begin
      @(negedge clk); #1;
      st++;
    end
    rd = cpu_rdata;
    @(posedge clk);
    if (we) begin
      exp_wa[pushes] = a[6:2]; exp_wd[pushes] = d; pushes++;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    cpu_req = 1'b0;
    while (wr_done != pushes || mem_req) @(negedge clk);
  endtask

  task automatic read_word(input int w, input int off, input string rq);
    logic [31:0] rd; int st; bit exp_miss;
    exp_miss = !(sh_v[w % 8] && sh_t[w % 8] == w / 8);
    access(1'b0, 7'(w * 4 + off), 32'd0, rd, st);
    chk((st > 0) == exp_miss, rq, "miss flag", 32'(st > 0), 32'(exp_miss));
    chk(rd == expmem[w], rq, "read data", rd, expmem[w]);
    if (exp_miss) begin sh_v[w % 8] = 1; sh_t[w % 8] = w / 8; end
    last_miss = exp_miss;
  endtask

  task automatic write_word(input int w, input logic [31:0] d, input string rq,
                            input bit exp_stall);
    logic [31:0] rd; int st;
    access(1'b1, 7'(w * 4), d, rd, st);
    chk((st > 0) == exp_stall, rq, "write stall", 32'(st), 32'(exp_stall));
    expmem[w] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int misses;
    for (int i = 0; i < 32; i++) begin mem[i] = memval(i); expmem[i] = memval(i); end
    for (int i = 0; i < 8; i++) begin sh_v[i] = 0; sh_t[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    chk(!cpu_stall && !mem_req, "R2", "idle after reset", {30'd0, cpu_stall, mem_req}, 32'd0);

    // R9: classic conflict sequence
    misses = 0;
    foreach (exp_wa[i]) if (i < 0) misses = 0;
    read_word(0, 0, "R9");  misses += int'(last_miss);
    read_word(8, 0, "R9");  misses += int'(last_miss);
    read_word(0, 0, "R9");  misses += int'(last_miss);
    read_word(6, 0, "R9");  misses += int'(last_miss);
    read_word(8, 0, "R9");  misses += int'(last_miss);
    read_word(16, 0, "R9"); misses += int'(last_miss);
    chk(misses == 6, "R9", "miss count", 32'(misses), 32'd6);
    read_word(16, 3, "R3");
    chk(!last_miss, "R3", "repeat is hit", 32'(last_miss), 32'd0);

    // R1/R4: sweep every word with varying byte offsets, then re-read
    for (int w = 0; w < 32; w++) read_word(w, w % 4, "R1");
    for (int w = 24; w < 32; w++) read_word(w, 3 - (w % 4), "R3");

    // R5: write hit
    write_word(25, 32'h1234_5678, "R5", 1'b0);
    read_word(25, 1, "R5");
    drain();
    chk(mem[25] == 32'h1234_5678, "R5", "memory updated", mem[25], 32'h1234_5678);

    // R6: write miss, no allocation
    write_word(1, 32'hDEAD_0001, "R6", 1'b0);
    drain();
    chk(mem[1] == 32'hDEAD_0001, "R6", "memory updated", mem[1], 32'hDEAD_0001);
    read_word(25, 0, "R6");
    chk(!last_miss, "R6", "line kept", 32'(last_miss), 32'd0);
    read_word(1, 2, "R6");
    chk(last_miss, "R6", "not allocated", 32'(last_miss), 32'd1);

    // R7: slow memory fills the buffer
    mem_lat = 8;
    drain();
    for (int k = 0; k < 4; k++) write_word(10 + k, 32'hB000_0000 + 32'(k), "R7", 1'b0);
    write_word(14, 32'hB000_0004, "R7", 1'b1);
    drain();
    for (int k = 0; k < 5; k++)
      chk(mem[10 + k] == expmem[10 + k], "R7", "memory content", mem[10 + k], expmem[10 + k]);

    // R8: read miss right behind a queued write to the same word
    write_word(3, 32'h5A5A_0003, "R8", 1'b0);
    read_word(3, 0, "R8");
    chk(last_miss, "R8", "was a miss", 32'(last_miss), 32'd1);
    mem_lat = 2;
    drain();

    // R2: reset mid-run invalidates lines
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk); rst = 1'b0;
    for (int i = 0; i < 8; i++) sh_v[i] = 0;
    read_word(3, 0, "R2");
    chk(last_miss, "R2", "miss after reset", 32'(last_miss), 32'd1);
    drain();

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule